// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a tag-to-reader reply of known length from a hysteresis-sliced receive signal. The reply has no start marker, stop marker or length field, so the block relies on timing alone. A start strobe marks the end of the outgoing reader frame. From that moment the block counts timer ticks and opens a run of fixed, back-to-back bit windows. In each window it counts level transitions of the sliced signal. A window holding roughly a subcarrier's worth of transitions is a 1. A quiet window, or one that is implausibly busy, is a 0.

While it waits for the first window, the block drives the external keystream generator. It first steps the generator twice. If decryption is requested, it then captures one keystream bit per expected data bit, stepping once after each. That mask is XORed into the decoded word when the last window closes. At the same moment the block pulses a request to clear the shared interval timer, so that the next reader frame lines up with the end of this reply.

Top module: `subcar_bit_rx`

## Requirements
- R1: After reset, `rx_valid`, `timer_clear` and `ks_step` are low, and `rx_data` and `rx_count` are zero.
- R2: The first bit window opens 490 ticks after the clock edge that accepts `frame_start`. Each window lasts 150 ticks, and the windows follow one another without gaps. With `tick_en` high on every clock, `rx_valid` is high in the cycle that follows edge 490 + 150·N, counting the accepting edge as edge 0.
- R3: A window decodes as 1 when its transition count is strictly greater than 20 and strictly less than 60. Every other count, including 20 and 60, decodes as 0.
- R4: A requested bit count above 16 is treated as 16, and `rx_count` reports the count actually received.
- R5: The bit from window k lands in `rx_data[k]`, so the first window is the least significant bit. Bits at and above `rx_count` are zero.
- R6: After each accepted start, `ks_step` pulses twice. When `decrypt_en` was high at the start, it then pulses N more times. Before each of those N steps, `ks_bit` is captured as mask bit k. The reported word is the decoded bits XOR the mask. Without decryption, no mask is applied.
- R7: `rx_valid` and `timer_clear` rise together for exactly one cycle when a frame ends.
- R8: Rising and falling transitions both count. The per-window counter saturates at its maximum (63 by default) instead of wrapping, so a window with 106 transitions decodes as 0.
- R9: A frame whose windows are all silent still ends with `rx_valid`, and `rx_data` is 0. A request for zero bits ends at the first window boundary with `rx_count` 0.
- R10: Timing is counted in `tick_en` cycles, not clock cycles. With `tick_en` high on every other clock, the windows stretch to match and decoding is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick qualifier |
| sliced_in | input | 1 | Hysteresis-sliced receive level (asynchronous) |
| frame_start | input | 1 | End of reader frame; accepted only when idle |
| req_bits | input | 5 | Number of reply bits wanted (clamped to 16) |
| decrypt_en | input | 1 | Apply the keystream mask to the result |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Advance the keystream generator by one |
| rx_data | output | 16 | Received word, first bit in bit 0 |
| rx_count | output | 5 | Number of bits in `rx_data` |
| rx_valid | output | 1 | One-cycle result strobe |
| timer_clear | output | 1 | One-cycle request to clear the shared interval timer |

## Verification
The bench places transition bursts of 20, 21, 59 and 60 edges, so a design that used inclusive bounds, or swapped them, decodes the wrong bit. It also places a 106-edge burst that a wrapping counter would fold into the 1 band. The bench checks the arrival cycle of the result at 490 + 150·N edges, so an off-by-one in the initial gap or the window length surfaces as a wrong cycle or as bits shifted between windows. The keystream model in the bench counts steps and predicts the mask after exactly two discarded steps; skipping, doubling or mis-ordering those steps yields a wrong word. Clamped requests, zero-bit requests, all-silent frames and a half-rate tick cover the remaining corners.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_BITS,
    ST_DONE
  } rx_state_e;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_PRE,
    KS_CAP
  } ks_phase_e;
endpackage

// File: rtl/sbr_tick_timer.sv
module sbr_tick_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;

  // Last tick of the interval
  assign expire = run && tick && (cnt_q == TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && tick && (cnt_q > TW'(1)))
      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a running interval never sits at zero
  a_r2_no_zero_interval: assert property (@(posedge clk) disable iff (!rst_n)
    run && !$past(load) && $past(run) |-> cnt_q != '0);
endmodule

// File: rtl/sbr_edge_count.sv
module sbr_edge_count #(
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_in,
  input  logic          en,
  input  logic          clr,
  output logic [EW-1:0] count
);
  localparam logic [EW-1:0] SAT = '1;

  logic s1_q, s2_q, s3_q;
  logic toggled;
  logic [EW-1:0] cnt_q, cnt_d;

  // Double-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign toggled = s2_q ^ s3_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && toggled && (cnt_q != SAT))
      cnt_d = cnt_q + EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R8: a full counter stays full until cleared
  a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && cnt_q == SAT |=> cnt_q == SAT);
  // R8: the count grows by at most one per clock
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + EW'(1)));
endmodule

// File: rtl/sbr_ks_mask.sv
module sbr_ks_mask
  import sbr_pkg::*;
#(
  parameter int MAXB = 16,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [CW-1:0]   nbits,
  input  logic            decrypt,
  input  logic            ks_bit,
  output logic            ks_step,
  output logic [MAXB-1:0] mask
);
  localparam int IW = (MAXB > 1) ? $clog2(MAXB) : 1;

  ks_phase_e       ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [MAXB-1:0] mask_q, mask_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    mask_d = mask_q;
    unique case (ph_q)
      KS_IDLE: begin
        if (go) begin
          ph_d   = KS_PRE;
          cnt_d  = '0;
          mask_d = '0;
        end
      end
      KS_PRE: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(1)) begin
          cnt_d = '0;
          ph_d  = (decrypt && nbits != '0) ? KS_CAP : KS_IDLE;
        end
      end
      KS_CAP: begin
        mask_d[cnt_q[IW-1:0]] = ks_bit;
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == nbits - CW'(1)) ph_d = KS_IDLE;
      end
      default: ph_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= KS_IDLE;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
    end
  end

  assign ks_step = (ph_q != KS_IDLE);
  assign mask    = mask_q;

  // Checker: steps issued since the last go
  logic [CW:0] steps_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       steps_q <= '0;
    else if (go)      steps_q <= '0;
    else if (ks_step) steps_q <= steps_q + 1'b1;
  end

  // R6: never more than two discarded steps plus one per bit
  a_r6_step_budget: assert property (@(posedge clk) disable iff (!rst_n)
    steps_q <= (CW+1)'(MAXB + 2));
  // R6: capture never indexes past the requested length
  a_r6_capture_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == KS_CAP |-> cnt_q < nbits);
endmodule

// File: rtl/subcar_bit_rx.sv
module subcar_bit_rx
  import sbr_pkg::*;
#(
  parameter int MAX_BITS  = 16,
  parameter int FIRST_GAP = 490,
  parameter int BIT_TICKS = 150,
  parameter int EDGE_LO   = 20,
  parameter int EDGE_HI   = 60,
  parameter int EDGE_W    = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick_en,
  input  logic                                sliced_in,
  input  logic                                frame_start,
  input  logic [$clog2(MAX_BITS+1)-1:0]       req_bits,
  input  logic                                decrypt_en,
  input  logic                                ks_bit,
  output logic                                ks_step,
  output logic [MAX_BITS-1:0]                 rx_data,
  output logic [$clog2(MAX_BITS+1)-1:0]       rx_count,
  output logic                                rx_valid,
  output logic                                timer_clear
);
  localparam int CW   = $clog2(MAX_BITS + 1);
  localparam int IW   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int TMAX = (FIRST_GAP > BIT_TICKS) ? FIRST_GAP : BIT_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  rx_state_e           st_q, st_d;
  logic [CW-1:0]       nbits_q, nbits_d;
  logic                dec_q, dec_d;
  logic [CW-1:0]       idx_q, idx_d;
  logic [MAX_BITS-1:0] shreg_q, shreg_d;
  logic [MAX_BITS-1:0] data_q, data_d;
  logic [CW-1:0]       count_q, count_d;

  logic                t_load, t_expire;
  logic [TW-1:0]       t_val;
  logic                e_clr;
  logic [EDGE_W-1:0]   e_cnt;
  logic                win_bit;
  logic                ks_go;
  logic [MAX_BITS-1:0] ks_mask;

  assign ks_go   = (st_q == ST_IDLE) && frame_start;
  assign win_bit = (e_cnt > EDGE_W'(EDGE_LO)) && (e_cnt < EDGE_W'(EDGE_HI));

  sbr_tick_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      ((st_q == ST_GAP) || (st_q == ST_BITS)),
    .tick     (tick_en),
    .load     (t_load),
    .load_val (t_val),
    .expire   (t_expire)
  );

  sbr_edge_count #(.EW(EDGE_W)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (sliced_in),
    .en     (st_q == ST_BITS),
    .clr    (e_clr),
    .count  (e_cnt)
  );

  sbr_ks_mask #(.MAXB(MAX_BITS), .CW(CW)) u_ks (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (ks_go),
    .nbits   (nbits_q),
    .decrypt (dec_q),
    .ks_bit  (ks_bit),
    .ks_step (ks_step),
    .mask    (ks_mask)
  );

  always_comb begin
    st_d    = st_q;
    nbits_d = nbits_q;
    dec_d   = dec_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    data_d  = data_q;
    count_d = count_q;
    t_load  = 1'b0;
    t_val   = TW'(BIT_TICKS);
    e_clr   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_start) begin
          st_d    = ST_GAP;
          nbits_d = (req_bits > CW'(MAX_BITS)) ? CW'(MAX_BITS) : req_bits;
          dec_d   = decrypt_en;
          idx_d   = '0;
          shreg_d = '0;
          t_load  = 1'b1;
          t_val   = TW'(FIRST_GAP);
        end
      end
      ST_GAP: begin
        if (t_expire) begin
          e_clr = 1'b1;
          if (nbits_q == '0) begin
            st_d    = ST_DONE;
            data_d  = '0;
            count_d = '0;
          end else begin
            st_d   = ST_BITS;
            t_load = 1'b1;
          end
        end
      end
      ST_BITS: begin
        if (t_expire) begin
          e_clr = 1'b1;
          shreg_d[idx_q[IW-1:0]] = win_bit;
          if (idx_q == nbits_q - CW'(1)) begin
            st_d    = ST_DONE;
            data_d  = shreg_d ^ (dec_q ? ks_mask : '0);
            count_d = nbits_q;
          end else begin
            idx_d  = idx_q + CW'(1);
            t_load = 1'b1;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      nbits_q <= '0;
      dec_q   <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '0;
      data_q  <= '0;
      count_q <= '0;
    end else begin
      st_q    <= st_d;
      nbits_q <= nbits_d;
      dec_q   <= dec_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      data_q  <= data_d;
      count_q <= count_d;
    end
  end

  assign rx_data     = data_q;
  assign rx_count    = count_q;
  assign rx_valid    = (st_q == ST_DONE);
  assign timer_clear = (st_q == ST_DONE);

  // R7: the result strobe lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R4: reported length never exceeds the limit
  a_r4_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_count <= CW'(MAX_BITS));
  // R5: window index stays below the requested length
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_BITS |-> idx_q < nbits_q);
  // R2: a new window starts with an empty edge count
  a_r2_fresh_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_BITS) |-> e_cnt == '0);
endmodule

// File: tb/tb_subcar_bit_rx.sv
module tb_subcar_bit_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        sliced_in;
  logic        frame_start;
  logic [4:0]  req_bits;
  logic        decrypt_en;
  logic        ks_bit;
  logic        ks_step;
  logic [15:0] rx_data;
  logic [4:0]  rx_count;
  logic        rx_valid;
  logic        timer_clear;

  always #10 clk = ~clk; // 50 MHz

  subcar_bit_rx dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sliced_in(sliced_in),
    .frame_start(frame_start), .req_bits(req_bits), .decrypt_en(decrypt_en),
    .ks_bit(ks_bit), .ks_step(ks_step), .rx_data(rx_data), .rx_count(rx_count),
    .rx_valid(rx_valid), .timer_clear(timer_clear)
  );

  typedef struct {
    logic [15:0] data;
    int          count;
    int          steps;
    int          when;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  int cyc = 0, steps = 0, tick_div = 1;
  int ed[16];
  logic [15:0] lfsr;
  bit finished = 0;

  function automatic logic [15:0] lfsr_next(logic [15:0] l);
    return {1'b0, l[15:1]} ^ (l[0] ? 16'hB400 : 16'h0000);
  endfunction

  assign ks_bit = lfsr[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && ks_step) begin
      lfsr  <= lfsr_next(lfsr);
      steps <= steps + 1;
    end
  end

  always @(negedge clk) tick_en <= (tick_div == 1) || cyc[0];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_frame(input int nreq, input bit dec, input int div);
    exp_t e;
    logic [15:0] l, mask, bits;
    int n, c0;
    n = (nreq > 16) ? 16 : nreq;
    tick_div = div;
    repeat (3) @(negedge clk);
    l = lfsr;
    l = lfsr_next(lfsr_next(l));
    mask = '0;
    bits = '0;
    for (int k = 0; k < n; k++) begin
      if (dec) begin
        mask[k] = l[0];
        l = lfsr_next(l);
      end
      bits[k] = (ed[k] > 20) && (ed[k] < 60);
    end
    e.data  = bits ^ mask;
    e.count = n;
    e.steps = 2 + (dec ? n : 0);
    steps = 0;
    frame_start = 1'b1;
    req_bits    = 5'(nreq);
    decrypt_en  = dec;
    @(negedge clk);
    c0 = cyc;
    e.when = (div == 1) ? c0 + 490 + 150 * n : -1;
    exp_q.push_back(e);
    frame_start = 1'b0;
    decrypt_en  = 1'b0;
    for (int i = 0; i < n; i++) begin
      int sp;
      sp = (ed[i] > 59) && (ed[i] > 100) ? 1 : 2;
      while (cyc < c0 + (491 + 150 * i + 20) * div) @(negedge clk);
      for (int j = 0; j < ed[i]; j++) begin
        sliced_in = ~sliced_in;
        repeat (sp * div) @(negedge clk);
      end
    end
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rx_data == e.data, "R3/R5/R6 data", int'(rx_data), int'(e.data));
        check(int'(rx_count) == e.count, "R4 count", int'(rx_count), e.count);
        check(steps == e.steps, "R6 keystream steps", steps, e.steps);
        check(timer_clear == 1'b1, "R7 timer_clear with valid", int'(timer_clear), 1);
        if (e.when >= 0)
          check(cyc == e.when, "R2 result cycle", cyc, e.when);
        @(negedge clk);
        check(!rx_valid && !timer_clear, "R7 one-cycle strobe", int'(rx_valid), 0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sliced_in = 1'b0;
    frame_start = 1'b0;
    req_bits = '0;
    decrypt_en = 1'b0;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rx_valid && !timer_clear && !ks_step, "R1 strobes low", int'({rx_valid, timer_clear, ks_step}), 0);
    check(rx_data == 0 && rx_count == 0, "R1 outputs zero", int'(rx_data), 0);
    rst_n = 1'b1;

    // R2/R5/R8: basic pattern, LSB first
    ed = '{42, 0, 42, 42, 0, 0, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(8, 1'b0, 1);
    // R3: threshold boundaries 20,21,59,60
    ed = '{20, 21, 59, 60, 30, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(6, 1'b0, 1);
    // R8: saturation, 106 edges must not wrap into the 1 band
    ed = '{106, 42, 106, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(3, 1'b0, 1);
    // R4: clamp 20 -> 16
    ed = '{42, 0, 0, 42, 42, 0, 42, 0, 0, 42, 42, 42, 0, 0, 0, 42};
    run_frame(20, 1'b0, 1);
    // R6: decryption mask
    ed = '{42, 42, 0, 0, 42, 0, 42, 0, 0, 42, 0, 42, 0, 0, 0, 0};
    run_frame(12, 1'b1, 1);
    // R9: all silent frame still valid with zero data
    ed = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(5, 1'b0, 1);
    // R9: zero-bit request ends at first window boundary
    run_frame(0, 1'b1, 1);
    // R10: half-rate tick, with decryption
    ed = '{0, 42, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(4, 1'b1, 2);
    finish_run();
  end
endmodule